// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block guards a small microcontroller against a stalled program. A tick arrives from one of three sources and advances a free-running prescaler followed by one final divider stage. When the full chain wraps, the block requests a reset. In normal operation that request resets the whole chip. While the core is powered down, it asks only for a wake reset, which restores the program counter and stack pointer. Both kinds of time-out set a sticky status flag.

Software keeps the watchdog quiet by clearing it. A static configuration input chooses the clear method. In single mode, one strobe is enough. In paired mode, two different half-strobes must arrive in alternation. A software clear resets only the final divider stage and leaves the prescaler residue in place, so the next time-out falls anywhere between 2^PRE_W and 2^(PRE_W+1) ticks later. A HALT strobe and the external reset clear the whole chain.

Everything runs on one clock. The oscillator and real-time-clock sources enter as one-cycle enable pulses. The system-clock source is divided by four inside the block.

Top module: `wdog_pair_clear`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `chip_rst_req`, `wake_rst_req` and `to_flag` are 0. Reset empties the whole divider chain, the clear-pending state and the divide-by-four counter.
- R2: The tick source is chosen from `src_sel`: 2'b00 selects `osc_tick`, 2'b01 selects the system clock divided by four, and 2'b10 or 2'b11 selects `rtc_tick`. When `sysclk_is_rtc` is 1, `rtc_tick` is used whatever `src_sel` holds.
- R3: The divided system-clock source gives one tick every fourth clock; after reset the first tick falls on the fourth rising edge. While `power_down` is 1 this source gives no ticks, so the watchdog never times out.
- R4: After reset or HALT, a time-out happens on exactly the 2^(PRE_W+1)-th tick.
- R5: A software clear resets only the final stage. If the prescaler holds residue p at the moment of the clear, the next time-out happens on exactly the (2^(PRE_W+1) - p)-th tick after the clear.
- R6: With `pair_mode` = 0, a `clr_single` strobe performs a software clear, and `clr_half1` and `clr_half2` have no effect.
- R7: With `pair_mode` = 1, a clear happens only when a `clr_half1` strobe and a `clr_half2` strobe arrive in either order, or in the same cycle. Repeating the half seen last has no effect, and `clr_single` has no effect.
- R8: A `halt` strobe clears the whole chain and forgets any half-strobe still waiting for its partner.
- R9: A time-out with `power_down` = 0 raises `chip_rst_req`. A time-out with `power_down` = 1 raises `wake_rst_req` instead. Either pulse is registered, lasts one cycle, and is seen in the cycle after the final tick.
- R10: `to_flag` goes to 1 on every time-out and stays there until `rst` or a `flag_clr` strobe clears it. A time-out in the same cycle as `flag_clr` leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | External reset, synchronous, active high |
| src_sel | input | 2 | Tick source select (static) |
| sysclk_is_rtc | input | 1 | System clock is the RTC oscillator; forces the RTC source |
| pair_mode | input | 1 | 0: single clear strobe; 1: paired clear (static) |
| osc_tick | input | 1 | One-cycle pulse from the internal watchdog oscillator |
| rtc_tick | input | 1 | One-cycle pulse from the RTC oscillator |
| power_down | input | 1 | Core is in power-down mode |
| clr_single | input | 1 | Single-instruction clear strobe |
| clr_half1 | input | 1 | First half of the paired clear |
| clr_half2 | input | 1 | Second half of the paired clear |
| halt | input | 1 | HALT instruction strobe; clears the whole chain |
| flag_clr | input | 1 | Clears the time-out status flag |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| wake_rst_req | output | 1 | One-cycle wake reset request from power-down |
| to_flag | output | 1 | Sticky time-out status flag |

## Verification
The chain state can only be seen through when the next reset request comes out, so any wrong internal value shows as a time-out on the wrong tick. A prescaler wrongly cleared by a software clear moves the request from 2^(PRE_W+1) - p ticks out to 2^(PRE_W+1). A half-strobe wrongly accepted or dropped moves it by the same residue. The bench therefore sets a known residue, applies each clear pattern and counts ticks up to the exact request cycle. It uses a small PRE_W, so every error shows within about a hundred ticks. A wrong source choice or a divide-by-four that still ticks in power-down shows as a request that comes when none is due, or as no request at all.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SRC_OSC  = 2'b00,
    SRC_SYS4 = 2'b01,
    SRC_RTC  = 2'b10,
    SRC_RTC2 = 2'b11
  } wdog_src_e;

  localparam int SYSDIV_W = 2;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       sysclk_is_rtc,
  input  logic       osc_tick,
  input  logic       rtc_tick,
  input  logic       power_down,
  output logic       tick
);
  logic [SYSDIV_W-1:0] div_q;
  logic                sys_tick;
  wdog_src_e           src;

  // System clock stops in power-down, so the divider freezes too.
  always_ff @(posedge clk) begin
    if (rst)              div_q <= '0;
    else if (!power_down) div_q <= div_q + 1'b1;
  end

  assign sys_tick = (&div_q) & ~power_down;

  always_comb begin
    src = sysclk_is_rtc ? SRC_RTC : wdog_src_e'(src_sel);
    case (src)
      SRC_OSC:  tick = osc_tick;
      SRC_SYS4: tick = sys_tick;
      default:  tick = rtc_tick;
    endcase
  end
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic pair_mode,
  input  logic clr_single,
  input  logic clr_half1,
  input  logic clr_half2,
  output logic sw_clr
);
  // pend_q[0]: half one seen last; pend_q[1]: half two seen last
  logic [1:0] pend_q, pend_d;
  logic       pair_done;

  always_comb begin
    pend_d    = pend_q;
    pair_done = 1'b0;
    if (pair_mode) begin
      if (clr_half1 && clr_half2) begin
        pair_done = 1'b1;
        pend_d    = 2'b00;
      end else if (clr_half1) begin
        if (pend_q[1]) begin
          pair_done = 1'b1;
          pend_d    = 2'b00;
        end else begin
          pend_d    = 2'b01;
        end
      end else if (clr_half2) begin
        if (pend_q[0]) begin
          pair_done = 1'b1;
          pend_d    = 2'b00;
        end else begin
          pend_d    = 2'b10;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || halt) pend_q <= 2'b00;
    else             pend_q <= pend_d;
  end

  assign sw_clr = pair_mode ? pair_done : clr_single;
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic tick,
  input  logic sw_clr,
  output logic expire
);
  localparam int CHAIN_W = PRE_W + 1;

  logic [CHAIN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick)   cnt_d = cnt_q + 1'b1;
    // Software clear touches only the last stage; the prescaler residue stays.
    if (sw_clr) cnt_d[CHAIN_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || halt) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign expire = tick & (&cnt_q) & ~sw_clr & ~halt;
endmodule

// File: rtl/wdog_pair_clear.sv
module wdog_pair_clear #(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       sysclk_is_rtc,
  input  logic       pair_mode,
  input  logic       osc_tick,
  input  logic       rtc_tick,
  input  logic       power_down,
  input  logic       clr_single,
  input  logic       clr_half1,
  input  logic       clr_half2,
  input  logic       halt,
  input  logic       flag_clr,
  output logic       chip_rst_req,
  output logic       wake_rst_req,
  output logic       to_flag
);
  logic tick;
  logic sw_clr;
  logic expire;

  wdog_tick_sel u_tick (
    .clk          (clk),
    .rst          (rst),
    .src_sel      (src_sel),
    .sysclk_is_rtc(sysclk_is_rtc),
    .osc_tick     (osc_tick),
    .rtc_tick     (rtc_tick),
    .power_down   (power_down),
    .tick         (tick)
  );

  wdog_clear_ctl u_clr (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .pair_mode (pair_mode),
    .clr_single(clr_single),
    .clr_half1 (clr_half1),
    .clr_half2 (clr_half2),
    .sw_clr    (sw_clr)
  );

  wdog_chain #(.PRE_W(PRE_W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .halt  (halt),
    .tick  (tick),
    .sw_clr(sw_clr),
    .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_rst_req <= 1'b0;
      wake_rst_req <= 1'b0;
      to_flag      <= 1'b0;
    end else begin
      chip_rst_req <= expire & ~power_down;
      wake_rst_req <= expire &  power_down;
      if (expire)        to_flag <= 1'b1;
      else if (flag_clr) to_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pair_clear_chk.sv
module wdog_pair_clear_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] src_sel,
  input logic       sysclk_is_rtc,
  input logic       power_down,
  input logic       flag_clr,
  input logic       chip_rst_req,
  input logic       wake_rst_req,
  input logic       to_flag
);
  // R9: never both request kinds at once
  a_r9_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(chip_rst_req && wake_rst_req));

  // R9: requests are single-cycle pulses
  a_r9_chip_pulse: assert property (@(posedge clk) disable iff (rst)
    chip_rst_req |=> !chip_rst_req);
  a_r9_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_rst_req |=> !wake_rst_req);

  // R9: the request kind follows the power state
  a_r9_wake_in_pd: assert property (@(posedge clk) disable iff (rst)
    (power_down && !chip_rst_req && !wake_rst_req) |=> !chip_rst_req);
  a_r9_chip_in_run: assert property (@(posedge clk) disable iff (rst)
    (!power_down && !chip_rst_req && !wake_rst_req) |=> !wake_rst_req);

  // R10: flag rises only together with a request
  a_r10_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> (chip_rst_req || wake_rst_req));

  // R10: flag holds without a clear strobe
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (to_flag && !flag_clr) |=> to_flag);

  // R3: divided system clock gives no tick in power-down
  a_r3_sys4_pd: assert property (@(posedge clk) disable iff (rst)
    (power_down && !sysclk_is_rtc && src_sel == 2'b01) |=> !wake_rst_req);
endmodule

bind wdog_pair_clear wdog_pair_clear_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_sel      (src_sel),
  .sysclk_is_rtc(sysclk_is_rtc),
  .power_down   (power_down),
  .flag_clr     (flag_clr),
  .chip_rst_req (chip_rst_req),
  .wake_rst_req (wake_rst_req),
  .to_flag      (to_flag)
);

// File: tb/wdog_pair_clear_test.sv
`timescale 1ns/1ps
module wdog_pair_clear_test;
  localparam int PRE_W = 6;
  localparam int FULL  = 1 << (PRE_W + 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel = 2'b00;
  logic       sysclk_is_rtc = 1'b0, pair_mode = 1'b0;
  logic       osc_tick = 1'b0, rtc_tick = 1'b0, power_down = 1'b0;
  logic       clr_single = 1'b0, clr_half1 = 1'b0, clr_half2 = 1'b0;
  logic       halt = 1'b0, flag_clr = 1'b0;
  logic       chip_rst_req, wake_rst_req, to_flag;

  int checks = 0;
  int errors = 0;
  bit use_rtc = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_pair_clear #(.PRE_W(PRE_W)) uut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .sysclk_is_rtc(sysclk_is_rtc),
    .pair_mode(pair_mode), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
    .power_down(power_down), .clr_single(clr_single), .clr_half1(clr_half1),
    .clr_half2(clr_half2), .halt(halt), .flag_clr(flag_clr),
    .chip_rst_req(chip_rst_req), .wake_rst_req(wake_rst_req), .to_flag(to_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Each tick: drive at a falling edge, sample one cycle later.
  task automatic run_ticks(input int n, output int chip_at, output int wake_at);
    chip_at = 0;
    wake_at = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (use_rtc) rtc_tick = 1'b1; else osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      rtc_tick = 1'b0;
      if (chip_rst_req && chip_at == 0) chip_at = i;
      if (wake_rst_req && wake_at == 0) wake_at = i;
    end
  endtask

  // 0 single, 1 half1, 2 half2, 3 halt, 4 flag_clr
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_single = 1'b1;
      1: clr_half1  = 1'b1;
      2: clr_half2  = 1'b1;
      3: halt       = 1'b1;
      default: flag_clr = 1'b1;
    endcase
    @(negedge clk);
    clr_single = 1'b0; clr_half1 = 1'b0; clr_half2 = 1'b0;
    halt = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic rtcsys, input logic pm,
                         input logic pd);
    src_sel = s; sysclk_is_rtc = rtcsys; pair_mode = pm; power_down = pd;
    use_rtc = 1'b0;
    do_reset();
  endtask

  task automatic test_reset();
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 chip_rst_req", chip_rst_req, 0);
    check("R1 wake_rst_req", wake_rst_req, 0);
    check("R1 to_flag", to_flag, 0);
  endtask

  task automatic test_full_timeout();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    run_ticks(FULL, c, w);
    check("R4 full chain tick count", c, FULL);
    check("R9 no wake in run mode", w, 0);
    @(negedge clk);
    check("R9 chip pulse one cycle", chip_rst_req, 0);
    check("R10 flag set", to_flag, 1);
    repeat (5) @(negedge clk);
    check("R10 flag held", to_flag, 1);
    strobe(4);
    check("R10 flag cleared by flag_clr", to_flag, 0);
  endtask

  task automatic test_residue_clear();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    run_ticks(100, c, w);
    strobe(0);
    run_ticks(FULL, c, w);
    check("R5 single clear keeps residue", c, FULL - 36);
  endtask

  task automatic test_single_ignores_halves();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    run_ticks(100, c, w);
    strobe(1);
    strobe(2);
    run_ticks(FULL, c, w);
    check("R6 halves ignored in single mode", c, FULL - 100);
  endtask

  task automatic test_pairs();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b1, 1'b0);
    run_ticks(100, c, w);
    strobe(1); strobe(1);
    run_ticks(FULL, c, w);
    check("R7 repeated half1 no clear", c, FULL - 100);
    set_cfg(2'b00, 1'b0, 1'b1, 1'b0);
    run_ticks(100, c, w);
    strobe(1); strobe(2);
    run_ticks(FULL, c, w);
    check("R7 half1 then half2 clears", c, FULL - 36);
    set_cfg(2'b00, 1'b0, 1'b1, 1'b0);
    run_ticks(100, c, w);
    strobe(2); strobe(2); strobe(1);
    run_ticks(FULL, c, w);
    check("R7 half2 then half1 clears", c, FULL - 36);
    set_cfg(2'b00, 1'b0, 1'b1, 1'b0);
    run_ticks(100, c, w);
    strobe(0);
    run_ticks(FULL, c, w);
    check("R7 clr_single ignored in paired mode", c, FULL - 100);
  endtask

  task automatic test_halt();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    run_ticks(100, c, w);
    strobe(3);
    run_ticks(FULL, c, w);
    check("R8 halt clears whole chain", c, FULL);
    set_cfg(2'b00, 1'b0, 1'b1, 1'b0);
    strobe(1);
    strobe(3);
    run_ticks(100, c, w);
    strobe(2);
    run_ticks(FULL, c, w);
    check("R8 halt forgets pending half", c, FULL - 100);
  endtask

  task automatic test_power_down();
    int c, w;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b1);
    run_ticks(FULL, c, w);
    check("R9 wake request in power-down", w, FULL);
    check("R9 no chip request in power-down", c, 0);
    check("R10 flag set by wake time-out", to_flag, 1);
  endtask

  task automatic test_sys4();
    int hit;
    set_cfg(2'b01, 1'b0, 1'b0, 1'b0);
    hit = 0;
    for (int i = 1; i <= 4 * FULL + 8; i++) begin
      @(negedge clk);
      if (chip_rst_req && hit == 0) hit = i;
    end
    check("R3 sys/4 cycles to time-out", hit, 4 * FULL);
    set_cfg(2'b01, 1'b0, 1'b0, 1'b1);
    hit = 0;
    for (int i = 1; i <= 4 * FULL + 8; i++) begin
      @(negedge clk);
      if ((chip_rst_req || wake_rst_req) && hit == 0) hit = i;
    end
    check("R3 sys/4 frozen in power-down", hit, 0);
  endtask

  task automatic test_rtc_forced();
    int c, w;
    set_cfg(2'b00, 1'b1, 1'b0, 1'b0);
    run_ticks(FULL + 4, c, w);
    check("R2 osc ignored when sysclk is rtc", c, 0);
    use_rtc = 1'b1;
    run_ticks(FULL, c, w);
    check("R2 rtc forced source", c, FULL);
    set_cfg(2'b10, 1'b0, 1'b0, 1'b0);
    use_rtc = 1'b1;
    run_ticks(FULL, c, w);
    check("R2 rtc selected by src_sel", c, FULL);
  endtask

  initial begin
    test_reset();
    test_full_timeout();
    test_residue_clear();
    test_single_ignores_halves();
    test_pairs();
    test_halt();
    test_power_down();
    test_sys4();
    test_rtc_forced();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule